// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block applies one tone curve to every component of a stream of 12-bit RGB pixels. The curve is held as 64 straight-line pieces. Each piece is stored as a coefficient word with a start value (intercept) and a slope scaled by 256. The pieces are fixed in position: one input code wide near black, then doubling in width group by group, and 128 codes wide over the bright range. For each component the block finds the piece that the code falls in. It adds the scaled slope times the distance from the start of the piece to the intercept, and saturates the result to 12 bits.

Coefficient words are loaded through a simple write port into a pending table. A frame-start strobe copies the whole pending table into the active table that the datapath reads. As a result, a frame never mixes two curves. The datapath is a three-register pipeline: piece lookup, multiply, then add and clamp. The valid flag travels alongside the data.

Top module: `gamma_pwl_eval`

## Requirements
- R1: Piece map over input code x: for x in 0..15 the piece index is x with start x; for x in 16..511, where p is the position of the highest set bit (4..8), the piece width is 2^(p-2), the index is 4*p + x[p-1:p-2] and the start is x with its low p-2 bits cleared; for x in 512..4095 the index is 32 + x[11:7] and the start is x with bits 6:0 cleared.
- R2: For one component the result is intercept + floor(slope * (x - start) / 256), where the coefficient word at the piece index carries the slope in bits 27:16 and the intercept in bits 11:0; bits 31:28 and 15:12 of the word have no effect.
- R3: A result above 4095 is output as 4095.
- R4: A pixel accepted with in_valid high at a rising edge appears with out_valid high right after the third rising edge counting that one, and back-to-back pixels come out back-to-back in order.
- R5: The same active table serves all three components; component k occupies bits [12k+11:12k] of both in_pix and out_pix.
- R6: A write (cfg_we high, word cfg_wdata to entry cfg_addr) lands in the pending table only and does not change any result until a later frame_start.
- R7: frame_start copies the pending table to the active table at that edge; a pixel accepted at the same edge still uses the previous active table, and a write at the same edge is not part of the copy.
- R8: After reset out_valid is low, out_pix is zero and both tables are zero, so every pixel evaluates to 0 until a table is committed.
- R9: out_valid is low in every cycle that corresponds to an input cycle without in_valid, and out_pix holds its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Commits the pending table to the active table |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 6 | Coefficient entry index |
| cfg_wdata | input | 32 | Coefficient word (slope 27:16, intercept 11:0) |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 36 | Three 12-bit components, component 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Three corrected 12-bit components |

## Verification
The frame-start commit can fall in the same cycle as an accepted pixel and in the same cycle as a coefficient write, and both coincidences are driven on purpose. A pixel presented with frame_start must still be evaluated with the old curve while the next pixel uses the new one. A word written together with frame_start must stay out of the active curve until another strobe, which is observed through the pixel results that read that entry. A behavioural model that keeps its own pending and active tables and a three-slot delay line is compared with the outputs on every clock, so any change in ordering shows up as a mismatch in the exact cycle.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
   localparam int FIELD_W   = 12;
   localparam int SLOPE_LSB = 16;
   localparam int ICPT_LSB  = 0;

   typedef struct packed {
      logic [FIELD_W-1:0] slope;
      logic [FIELD_W-1:0] icpt;
   } coef_t;

   localparam int COEF_W = $bits(coef_t);
endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode #(
   parameter int DATA_W = 12,
   parameter int TBL_AW = 6,
   parameter int OFF_W  = 7
) (
   input  logic [DATA_W-1:0] code,
   output logic [TBL_AW-1:0] seg_idx,
   output logic [OFF_W-1:0]  seg_off
);
   localparam int FINE_BITS = 4;
   localparam int MID_TOP   = 8;
   localparam int HI_LSB    = 7;

   logic [DATA_W-1:0] sub_sel;
   logic [DATA_W-1:0] mask;
   int                msb;

   always_comb begin
      msb     = 0;
      sub_sel = '0;
      mask    = '0;
      seg_idx = '0;
      seg_off = '0;
      if (code[DATA_W-1:MID_TOP+1] != '0) begin
         seg_idx = TBL_AW'(32) + TBL_AW'(code[DATA_W-1:HI_LSB]);
         seg_off = OFF_W'(code[HI_LSB-1:0]);
      end else if (code[MID_TOP:FINE_BITS] != '0) begin
         for (int b = FINE_BITS; b <= MID_TOP; b++) begin
            if (code[b]) msb = b;
         end
         sub_sel = (code >> (msb - 2)) & DATA_W'(3);
         mask    = (DATA_W'(1) << (msb - 2)) - DATA_W'(1);
         seg_idx = TBL_AW'(4 * msb) + TBL_AW'(sub_sel);
         seg_off = OFF_W'(code & mask);
      end else begin
         seg_idx = TBL_AW'(code[FINE_BITS-1:0]);
         seg_off = '0;
      end
   end
endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
   import gamma_pkg::*;
#(
   parameter int TBL_AW = 6,
   parameter int WORD_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [TBL_AW-1:0]              wr_addr,
   input  logic [WORD_W-1:0]              wr_word,
   input  logic                           commit,
   output logic [(1<<TBL_AW)*COEF_W-1:0]  act_flat,
   output logic [(1<<TBL_AW)*COEF_W-1:0]  pend_flat
);
   localparam int DEPTH = 1 << TBL_AW;

   coef_t wr_coef;
   assign wr_coef.slope = wr_word[SLOPE_LSB +: FIELD_W];
   assign wr_coef.icpt  = wr_word[ICPT_LSB  +: FIELD_W];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      coef_t pend_q, act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
         end else begin
            if (wr_en && (wr_addr == TBL_AW'(i))) pend_q <= wr_coef;
            if (commit) act_q <= pend_q;
         end
      end
      assign act_flat [i*COEF_W +: COEF_W] = act_q;
      assign pend_flat[i*COEF_W +: COEF_W] = pend_q;
   end
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
   import gamma_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int TBL_AW   = 6,
   parameter int SLOPE_SH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          v0,
   input  logic                          v1,
   input  logic                          v2,
   input  logic [DATA_W-1:0]             code,
   input  logic [(1<<TBL_AW)*COEF_W-1:0] act_flat,
   output logic [DATA_W-1:0]             result
);
   localparam int OFF_W  = 7;
   localparam int PROD_W = FIELD_W + OFF_W;
   localparam int SUM_W  = DATA_W + 1;
   localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << DATA_W) - 1);

   logic [TBL_AW-1:0] seg_idx;
   logic [OFF_W-1:0]  seg_off;
   coef_t             coef_rd;

   gamma_seg_decode #(.DATA_W(DATA_W), .TBL_AW(TBL_AW), .OFF_W(OFF_W)) u_dec (
      .code    (code),
      .seg_idx (seg_idx),
      .seg_off (seg_off)
   );

   assign coef_rd = act_flat[seg_idx*COEF_W +: COEF_W];

   // stage 1: lookup
   logic [FIELD_W-1:0] s1_slope, s1_icpt;
   logic [OFF_W-1:0]   s1_off;
   // stage 2: multiply
   logic [PROD_W-1:0]  s2_prod;
   logic [FIELD_W-1:0] s2_icpt;
   logic [SUM_W-1:0]   sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_slope <= '0;
         s1_icpt  <= '0;
         s1_off   <= '0;
         s2_prod  <= '0;
         s2_icpt  <= '0;
         result   <= '0;
      end else begin
         if (v0) begin
            s1_slope <= coef_rd.slope;
            s1_icpt  <= coef_rd.icpt;
            s1_off   <= seg_off;
         end
         if (v1) begin
            s2_prod <= PROD_W'(s1_slope) * PROD_W'(s1_off);
            s2_icpt <= s1_icpt;
         end
         if (v2) result <= (sum > MAXV) ? DATA_W'(MAXV) : sum[DATA_W-1:0];
      end
   end

   assign sum = SUM_W'(s2_icpt) + SUM_W'(s2_prod >> SLOPE_SH);
endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
   import gamma_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int NUM_CH   = 3,
   parameter int TBL_AW   = 6,
   parameter int WORD_W   = 32,
   parameter int SLOPE_SH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_start,
   input  logic                     cfg_we,
   input  logic [TBL_AW-1:0]        cfg_addr,
   input  logic [WORD_W-1:0]        cfg_wdata,
   input  logic                     in_valid,
   input  logic [NUM_CH*DATA_W-1:0] in_pix,
   output logic                     out_valid,
   output logic [NUM_CH*DATA_W-1:0] out_pix
);
   localparam int DEPTH  = 1 << TBL_AW;
   localparam int FLAT_W = DEPTH * COEF_W;

   if (DATA_W != 12) begin : g_chk_dw
      $error("gamma_pwl_eval: piece map requires DATA_W of 12");
   end
   if (TBL_AW != 6) begin : g_chk_aw
      $error("gamma_pwl_eval: piece map requires 64 entries");
   end
   if (WORD_W < SLOPE_LSB + FIELD_W) begin : g_chk_ww
      $error("gamma_pwl_eval: coefficient word too narrow");
   end
   if (NUM_CH < 1) begin : g_chk_ch
      $error("gamma_pwl_eval: need at least one channel");
   end

   logic [FLAT_W-1:0] act_flat;
   logic [FLAT_W-1:0] pend_flat;
   logic              v1, v2, v3;

   gamma_coef_bank #(.TBL_AW(TBL_AW), .WORD_W(WORD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_addr   (cfg_addr),
      .wr_word   (cfg_wdata),
      .commit    (frame_start),
      .act_flat  (act_flat),
      .pend_flat (pend_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         v3 <= v2;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      gamma_lane #(.DATA_W(DATA_W), .TBL_AW(TBL_AW), .SLOPE_SH(SLOPE_SH)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .v0       (in_valid),
         .v1       (v1),
         .v2       (v2),
         .code     (in_pix[c*DATA_W +: DATA_W]),
         .act_flat (act_flat),
         .result   (out_pix[c*DATA_W +: DATA_W])
      );
   end

   assign out_valid = v3;
endmodule

// File: rtl/gamma_pwl_eval_chk.sv
module gamma_pwl_eval_chk #(
   parameter int PIX_W  = 36,
   parameter int FLAT_W = 1536
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              in_valid,
   input logic              out_valid,
   input logic [PIX_W-1:0]  out_pix,
   input logic [FLAT_W-1:0] act_flat,
   input logic [FLAT_W-1:0] pend_flat
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R4

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst != 2'd0) && !out_valid) |-> $stable(out_pix)); // R9

   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst != 2'd0) && $past(frame_start)) |-> (act_flat == $past(pend_flat))); // R7

   AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst != 2'd0) && !$past(frame_start)) |-> $stable(act_flat)); // R6
endmodule

bind gamma_pwl_eval gamma_pwl_eval_chk #(
   .PIX_W  (NUM_CH * DATA_W),
   .FLAT_W ((1 << TBL_AW) * gamma_pkg::COEF_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_pix     (out_pix),
   .act_flat    (act_flat),
   .pend_flat   (pend_flat)
);

// File: tb/gamma_pwl_eval_bench.sv
module gamma_pwl_eval_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [35:0] in_pix = '0;
   logic        out_valid;
   logic [35:0] out_pix;

   always #10 clk = ~clk;

   gamma_pwl_eval u_gamma_pwl_eval (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R8";
   bit    done = 1'b0;

   // reference model state
   int seg_lo [65];
   int pend [64];
   int act  [64];
   bit m_v [3];
   int m_p [3][3];

   function automatic int seg_of(int x);
      for (int i = 0; i < 64; i++)
         if (x >= seg_lo[i] && x < seg_lo[i+1]) return i;
      return 0;
   endfunction

   function automatic int eval(int x);
      int i, sl, ic, r;
      i  = seg_of(x);
      sl = (act[i] >> 16) & 12'hFFF;
      ic = act[i] & 12'hFFF;
      r  = ic + (sl * (x - seg_lo[i])) / 256;
      return (r > 4095) ? 4095 : r;
   endfunction

   initial begin
      int n, lo;
      n = 0; lo = 0;
      for (int i = 0; i < 16; i++) begin seg_lo[n] = lo; lo += 1; n++; end
      for (int w = 4; w <= 64; w *= 2)
         for (int k = 0; k < 4; k++) begin seg_lo[n] = lo; lo += w; n++; end
      for (int k = 0; k < 28; k++) begin seg_lo[n] = lo; lo += 128; n++; end
      seg_lo[64] = lo;
      for (int i = 0; i < 64; i++) begin pend[i] = 0; act[i] = 0; end
      for (int s = 0; s < 3; s++) m_v[s] = 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin pend[i] = 0; act[i] = 0; end
         for (int s = 0; s < 3; s++) m_v[s] = 1'b0;
      end else begin
         m_v[2] = m_v[1]; m_v[1] = m_v[0]; m_v[0] = in_valid;
         if (m_v[2]) m_p[2] = m_p[1];
         if (m_v[1]) m_p[1] = m_p[0];
         if (in_valid)
            for (int c = 0; c < 3; c++) m_p[0][c] = eval(int'(in_pix[c*12 +: 12]));
         if (frame_start)
            for (int i = 0; i < 64; i++) act[i] = pend[i];
         if (cfg_we) pend[cfg_addr] = int'(cfg_wdata);
      end
   end

   int held [3];
   initial for (int c = 0; c < 3; c++) held[c] = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (out_valid !== m_v[2]) begin
            failures++;
            $display("FAIL %s out_valid act=%0d exp=%0d", cur_req, out_valid, m_v[2]);
         end
         if (m_v[2]) for (int c = 0; c < 3; c++) held[c] = m_p[2][c];
         for (int c = 0; c < 3; c++) begin
            checks++;
            if (int'(out_pix[c*12 +: 12]) != held[c]) begin
               failures++;
               $display("FAIL %s ch%0d out_pix act=%0d exp=%0d", cur_req, c,
                        out_pix[c*12 +: 12], held[c]);
            end
         end
      end
   end

   task automatic step(bit fs, bit we, int a, int d, bit v, int r, int g, int b);
      frame_start = fs; cfg_we = we; cfg_addr = 6'(a); cfg_wdata = 32'(d);
      in_valid = v; in_pix = {12'(b), 12'(g), 12'(r)};
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   function automatic int mk(int sl, int ic);
      return (32'hA << 28) | ((sl & 12'hFFF) << 16) | (32'h5 << 12) | (ic & 12'hFFF);
   endfunction

   int bnd [18] = '{0, 1, 15, 16, 19, 20, 31, 32, 63, 64, 127, 128, 255, 256, 511, 512, 639, 4095};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state, zero tables give zero output
      cur_req = "R8";
      idle(2);
      step(0, 0, 0, 0, 1, 4095, 100, 7);
      step(0, 0, 0, 0, 1, 512, 3, 2000);
      idle(4);
      // R6: load identity curve into pending table, no effect yet
      cur_req = "R6";
      for (int i = 0; i < 64; i++) step(0, 1, i, mk(256, seg_lo[i]), 1, 700 + i, i, 4000 - i);
      idle(4);
      // R7: commit; same-edge pixel uses old table, write at same edge excluded
      cur_req = "R7";
      step(1, 1, 63, mk(0, 5), 1, 3000, 10, 600);
      step(0, 0, 0, 0, 1, 3000, 10, 600);
      step(0, 0, 0, 0, 1, 4095, 3968, 4000);
      idle(4);
      step(1, 0, 0, 0, 1, 4095, 12, 13);
      step(0, 0, 0, 0, 1, 4095, 3968, 4000);
      idle(4);
      // R1: distinct per-entry curve, sweep segment boundaries
      cur_req = "R1";
      for (int i = 0; i < 64; i++) step(0, 1, i, mk((i * 397) % 4096, i * 61), 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      foreach (bnd[k]) step(0, 0, 0, 0, 1, bnd[k], bnd[k] == 0 ? 0 : bnd[k] - 1, bnd[k] + 1);
      idle(4);
      // R2: many codes across every piece
      cur_req = "R2";
      for (int x = 0; x < 4096; x += 37) step(0, 0, 0, 0, 1, x, 4095 - x, (x * 7) % 4096);
      idle(4);
      // R3: saturation at the top entry
      cur_req = "R3";
      step(0, 1, 63, mk(4095, 4095), 0, 0, 0, 0);
      step(0, 1, 40, mk(4095, 4000), 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 4095, 3968, 1663);
      step(0, 0, 0, 0, 1, 1663, 1536, 4000);
      idle(4);
      // R5: one table for all components, lane placement
      cur_req = "R5";
      step(0, 0, 0, 0, 1, 5, 300, 2900);
      step(0, 0, 0, 0, 1, 2900, 5, 300);
      step(0, 0, 0, 0, 1, 300, 2900, 5);
      idle(4);
      // R4: back-to-back stream
      cur_req = "R4";
      for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 1, k * 101, k * 13, 4095 - k * 7);
      idle(4);
      // R9: bubbles, output holds
      cur_req = "R9";
      for (int k = 0; k < 30; k++) step(0, 0, 0, 0, (k % 3) != 1, k * 131, k * 17, k * 3);
      idle(6);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule